// File: doc/BRIEF.md
# Complementary Mosaic Y/C Separator

This block sits behind the digitiser of an interline colour CCD fitted with a yellow, cyan, magenta and green mosaic. In field readout the sensor mixes two vertically adjacent photosites per output sample. The horizontal register therefore delivers a repeating two-sample pattern that depends on the line. One kind of line gives (G+Cy) then (Mg+Ye). The other kind gives (Mg+Cy) then (G+Ye). For each pair of consecutive samples, the block forms luminance as half their sum and a colour-difference value as their signed difference (second minus first). It labels that difference as R−Y or −(B−Y) according to the current line kind.

The host marks the first valid sample of every line with a line-start strobe. It marks the first line of every field with a field-start strobe and a parity bit. The parity picks the line kind of the field's first line. The kind then flips at each further line start. Pairing restarts at every line start, so no pair ever spans two lines. Each completed pair yields one output word two clock cycles after its second sample is taken.

Top module: `ycsep_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_vld` is 0 and `y_out` and `c_out` are 0.
- R2: For a pair whose first sample is a and whose second is b (10-bit unsigned), `y_out` equals floor((a+b)/2), using the full 11-bit sum before halving.
- R3: For the same pair, `c_out` equals b−a as an 11-bit two's-complement value. The range is −1023 to +1023.
- R4: `c_is_rmy` is 1 when the chroma of the pair is R−Y (first-kind line) and 0 when it is −(B−Y) (second-kind line). The line kind inverts at every accepted line start that is not also a field start. After reset the kind is the first kind.
- R5: An accepted field start sets the kind of the field's first line to the first kind when `field_odd` is 1 and to the second kind when `field_odd` is 0.
- R6: An accepted line start makes its sample the first of a new pair. An unpaired sample left at the end of the previous line is dropped and produces no output.
- R7: Each completed pair produces exactly one output cycle. `out_vld` goes high for one cycle, two rising edges after the edge that takes the pair's second sample.
- R8: `line_start`, `field_start` and `field_odd` are taken only in cycles where `smp_vld` is 1. In other cycles they change neither pairing nor line kind.
- R9: Idle cycles (`smp_vld` low) between the two samples of a pair do not break the pair. Latency is counted from the second sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample on `smp_data` is valid this cycle |
| smp_data | input | 10 | Mixed two-pixel sample, unsigned |
| line_start | input | 1 | This valid sample is the first of a line |
| field_start | input | 1 | This valid sample is the first of a field (also starts a line) |
| field_odd | input | 1 | Field parity, taken with `field_start` |
| out_vld | output | 1 | Output word valid, one cycle per pair |
| y_out | output | 10 | Luminance, half the pair sum |
| c_out | output | 11 | Colour difference, second minus first, two's complement |
| c_is_rmy | output | 1 | 1: `c_out` is R−Y; 0: `c_out` is −(B−Y) |

## Verification
On every cycle, the assertions check these behaviours:
- a completed pair appears at the output exactly two cycles later, and no output cycle appears without such a pair;
- a sample that opens a line is never treated as the closing half of a pair;
- a field start loads the line kind named by the parity bit.

The arithmetic of Y and C, the alternation of the chroma label over many lines, the dropping of an orphan sample, and the insensitivity to strobes on idle cycles are shown only by the bench's scenarios. The bench compares each output word against a model that is fed the same sample stream.

// File: rtl/ycsep_pkg.sv
package ycsep_pkg;

    // Kind of the current line; value 1 means chroma of the pair is R-Y.
    typedef enum logic {
        KIND_BMY = 1'b0,
        KIND_RMY = 1'b1
    } line_kind_e;

    // Phase of the next accepted sample within its pair.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pair_phase_e;

endpackage

// File: rtl/ycsep_seq.sv
module ycsep_seq
    import ycsep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_vld,
    input  logic       line_start,
    input  logic       field_start,
    input  logic       field_odd,
    output logic       take_first,
    output logic       pair_done,
    output line_kind_e line_kind
);

    typedef struct packed {
        pair_phase_e phase;
        line_kind_e  kind;
    } seq_state_t;

    seq_state_t state_d, state_q;
    logic       opens_line;

    always_comb begin
        state_d    = state_q;
        opens_line = smp_vld && (line_start || field_start);
        take_first = 1'b0;
        pair_done  = 1'b0;
        if (smp_vld) begin
            if (opens_line) begin
                take_first    = 1'b1;
                state_d.phase = PH_SECOND;
                if (field_start) begin
                    state_d.kind = field_odd ? KIND_RMY : KIND_BMY;
                end else begin
                    state_d.kind = (state_q.kind == KIND_RMY) ? KIND_BMY : KIND_RMY;
                end
            end else if (state_q.phase == PH_FIRST) begin
                take_first    = 1'b1;
                state_d.phase = PH_SECOND;
            end else begin
                pair_done     = 1'b1;
                state_d.phase = PH_FIRST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_FIRST, kind: KIND_RMY};
        end else begin
            state_q <= state_d;
        end
    end

    assign line_kind = state_q.kind;

    // A sample that opens a line never closes a pair.
    assert_no_cross_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && line_start) |-> !pair_done);

    // Field parity selects the first line kind.
    assert_field_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && field_start) |=> (line_kind == ($past(field_odd) ? KIND_RMY : KIND_BMY)));

endmodule

// File: rtl/ycsep_arith.sv
module ycsep_arith
    import ycsep_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_first,
    input  logic                 pair_done,
    input  line_kind_e           kind_in,
    input  logic [DATA_W-1:0]    smp_data,
    output logic                 st_vld,
    output logic [DATA_W:0]      st_sum,
    output logic [DATA_W:0]      st_diff,
    output line_kind_e           st_kind
);

    localparam int EXT_W = DATA_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] first;
        logic              vld;
        logic [EXT_W-1:0]  sum;
        logic [EXT_W-1:0]  diff;
        line_kind_e        kind;
    } arith_state_t;

    arith_state_t     state_d, state_q;
    logic [EXT_W-1:0] a_ext, b_ext;

    always_comb begin
        state_d     = state_q;
        a_ext       = {1'b0, state_q.first};
        b_ext       = {1'b0, smp_data};
        state_d.vld = pair_done;
        if (take_first) begin
            state_d.first = smp_data;
        end
        if (pair_done) begin
            state_d.sum  = a_ext + b_ext;
            state_d.diff = b_ext - a_ext;
            state_d.kind = kind_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{first: '0, vld: 1'b0, sum: '0, diff: '0, kind: KIND_RMY};
        end else begin
            state_q <= state_d;
        end
    end

    assign st_vld  = state_q.vld;
    assign st_sum  = state_q.sum;
    assign st_diff = state_q.diff;
    assign st_kind = state_q.kind;

endmodule

// File: rtl/ycsep_outreg.sv
module ycsep_outreg
    import ycsep_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_vld,
    input  logic [DATA_W:0]   st_sum,
    input  logic [DATA_W:0]   st_diff,
    input  line_kind_e        st_kind,
    output logic              out_vld,
    output logic [DATA_W-1:0] y_out,
    output logic [DATA_W:0]   c_out,
    output logic              c_is_rmy
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] y;
        logic [DATA_W:0]   c;
        logic              rmy;
    } out_state_t;

    out_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.vld = st_vld;
        if (st_vld) begin
            state_d.y   = st_sum[DATA_W:1];
            state_d.c   = st_diff;
            state_d.rmy = (st_kind == KIND_RMY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{vld: 1'b0, y: '0, c: '0, rmy: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign out_vld  = state_q.vld;
    assign y_out    = state_q.y;
    assign c_out    = state_q.c;
    assign c_is_rmy = state_q.rmy;

endmodule

// File: rtl/ycsep_top.sv
module ycsep_top
    import ycsep_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              line_start,
    input  logic              field_start,
    input  logic              field_odd,
    output logic              out_vld,
    output logic [DATA_W-1:0] y_out,
    output logic [DATA_W:0]   c_out,
    output logic              c_is_rmy
);

    logic            take_first;
    logic            pair_done;
    line_kind_e      line_kind;
    logic            st_vld;
    logic [DATA_W:0] st_sum;
    logic [DATA_W:0] st_diff;
    line_kind_e      st_kind;

    ycsep_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .line_start  (line_start),
        .field_start (field_start),
        .field_odd   (field_odd),
        .take_first  (take_first),
        .pair_done   (pair_done),
        .line_kind   (line_kind)
    );

    ycsep_arith #(.DATA_W(DATA_W)) u_arith (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_first (take_first),
        .pair_done  (pair_done),
        .kind_in    (line_kind),
        .smp_data   (smp_data),
        .st_vld     (st_vld),
        .st_sum     (st_sum),
        .st_diff    (st_diff),
        .st_kind    (st_kind)
    );

    ycsep_outreg #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_vld   (st_vld),
        .st_sum   (st_sum),
        .st_diff  (st_diff),
        .st_kind  (st_kind),
        .out_vld  (out_vld),
        .y_out    (y_out),
        .c_out    (c_out),
        .c_is_rmy (c_is_rmy)
    );

    // A completed pair reaches the output exactly two cycles later.
    assert_pair_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |-> ##2 out_vld);

    // No output cycle without a pair completed two cycles before.
    assert_no_spurious_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(pair_done, 2));

endmodule

// File: tb/ycsep_top_test.sv
module ycsep_top_test;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          line_start = 1'b0;
    logic          field_start = 1'b0;
    logic          field_odd = 1'b0;
    logic          out_vld;
    logic [DW-1:0] y_out;
    logic [DW:0]   c_out;
    logic          c_is_rmy;

    always #4 clk = ~clk;

    ycsep_top #(.DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_data    (smp_data),
        .line_start  (line_start),
        .field_start (field_start),
        .field_odd   (field_odd),
        .out_vld     (out_vld),
        .y_out       (y_out),
        .c_out       (c_out),
        .c_is_rmy    (c_is_rmy)
    );

    typedef struct packed {
        logic [DW-1:0] y;
        logic [DW:0]   c;
        logic          rmy;
        int unsigned   due;
    } exp_t;

    exp_t        exp_q[$];
    string       tag_q[$];
    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    string       cur_tag = "R2";

    // Reference model state.
    bit          m_second = 1'b0;
    bit          m_rmy = 1'b1;
    logic [DW-1:0] m_first = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int d, input bit ls, input bit fs, input bit fo);
        logic [DW:0] a, b;
        exp_t e;
        @(negedge clk);
        smp_vld     = 1'b1;
        smp_data    = DW'(d);
        line_start  = ls;
        field_start = fs;
        field_odd   = fo;
        if (ls || fs) begin
            m_rmy    = fs ? fo : ~m_rmy;
            m_first  = DW'(d);
            m_second = 1'b1;
        end else if (!m_second) begin
            m_first  = DW'(d);
            m_second = 1'b1;
        end else begin
            a = {1'b0, m_first};
            b = {1'b0, DW'(d)};
            e.y   = DW'((a + b) >> 1);
            e.c   = b - a;
            e.rmy = m_rmy;
            e.due = cyc + 2;
            exp_q.push_back(e);
            tag_q.push_back(cur_tag);
            m_second = 1'b0;
        end
    endtask

    task automatic idle(input int n, input bit ls, input bit fs, input bit fo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld     = 1'b0;
            line_start  = ls;
            field_start = fs;
            field_odd   = fo;
            smp_data    = 10'h3A5;
        end
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && !finished && out_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected output", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(y_out == e.y, "R2", {t, " Y"}, int'(y_out), int'(e.y));
                check(c_out == e.c, "R3", {t, " C"}, int'($signed(c_out)), int'($signed(e.c)));
                check(c_is_rmy == e.rmy, "R4", {t, " chroma kind"}, int'(c_is_rmy), int'(e.rmy));
                check(cyc == e.due, "R7", {t, " latency cycle"}, int'(cyc), int'(e.due));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and just after reset.
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0 && y_out == '0 && c_out == '0, "R1", "outputs in reset",
              int'(out_vld) + int'(y_out) + int'(c_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0 && y_out == '0 && c_out == '0, "R1", "outputs after reset",
              int'(out_vld) + int'(y_out) + int'(c_out), 0);

        // R5: odd field starts with first-kind lines; R2/R3 main pattern.
        cur_tag = "R5 odd field line";
        put(300, 1, 1, 1); put(420, 0, 0, 0);
        put(310, 0, 0, 0); put(400, 0, 0, 0);
        put(305, 0, 0, 0); put(410, 0, 0, 0);
        // R4: second line flips the kind.
        cur_tag = "R4 second line";
        put(500, 1, 0, 0); put(260, 0, 0, 0);
        put(480, 0, 0, 0); put(270, 0, 0, 0);
        // R6: third line has an orphan sample at its end.
        cur_tag = "R6 orphan line";
        put(100, 1, 0, 0); put(101, 0, 0, 0);
        put(900, 0, 0, 0);
        // R6: next line restarts pairing, orphan dropped.
        cur_tag = "R6 after orphan";
        put(20, 1, 0, 0); put(40, 0, 0, 0);
        idle(4, 0, 0, 0);

        // R2/R3 boundaries.
        cur_tag = "R3 extremes";
        put(1023, 1, 0, 0); put(1023, 0, 0, 0);
        put(0, 0, 0, 0);    put(1023, 0, 0, 0);
        put(1023, 0, 0, 0); put(0, 0, 0, 0);
        put(0, 0, 0, 0);    put(0, 0, 0, 0);
        put(1, 0, 0, 0);    put(2, 0, 0, 0);
        idle(3, 0, 0, 0);

        // R9: idle cycles inside a pair.
        cur_tag = "R9 gapped pair";
        put(700, 1, 0, 0); idle(3, 0, 0, 0); put(650, 0, 0, 0);
        idle(2, 0, 0, 0);
        put(11, 0, 0, 0); idle(1, 0, 0, 0); put(999, 0, 0, 0);
        idle(3, 0, 0, 0);

        // R8: strobes on idle cycles are ignored (mid-pair and between pairs).
        cur_tag = "R8 idle strobes";
        put(200, 1, 0, 0);
        idle(2, 1, 1, 0);
        put(600, 0, 0, 0);
        idle(1, 1, 0, 1);
        put(333, 0, 0, 0); put(111, 0, 0, 0);
        idle(4, 0, 0, 0);

        // R5: even field starts with second-kind lines, then alternates (R4).
        cur_tag = "R5 even field line";
        put(400, 1, 1, 0); put(520, 0, 0, 0);
        cur_tag = "R4 even field next line";
        put(410, 1, 0, 0); put(380, 0, 0, 0);
        cur_tag = "R4 even field third line";
        put(90, 1, 0, 0); put(95, 0, 0, 0);
        // R5: an odd field start mid-stream restores the first kind.
        cur_tag = "R5 new odd field";
        put(123, 1, 1, 1); put(456, 0, 0, 0);
        put(789, 0, 0, 0); put(12, 0, 0, 0);
        idle(6, 0, 0, 0);

        check(exp_q.size() == 0, "R7", "pending outputs at end", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule